// File: doc/BRIEF.md
# Priority Interrupt Level Arbiter

This block collects interrupt requests on fifteen prioritised levels (1 to 15; level 0 is the idle code and carries no request) and decides, every cycle, whether the processor must be asked to take an asynchronous trap. It keeps a sticky pending bit per level, picks the highest pending level, and compares it with the processor's current interrupt mask level. Level 15 is the exception to the mask: it is always taken. Nothing is issued while the global trap enable is low. When a request is issued, the block also supplies the trap type for that level.

A second bank of sixteen extended sources, numbered 16 to 31, is funnelled onto one primary level that the integrator selects. The block latches which extended sources fired and presents the identity of the highest-numbered pending one, so a handler entered on the shared level can find out which source caused it. When the processor acknowledges the trap, the block clears the pending state of the level it serviced. A separate clear strobe lets software drop a single extended source.

Top module: `pil_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, trap_req_o is 0, trap_type_o is 0, ext_id_vld_o is 0 and ext_id_o is 0.
- R2: A 1 on irq_i[n] (n from 1 to 15) at a rising clock edge latches level n as pending. The pending bit is visible on the outputs from that same edge and stays set after the input returns to 0.
- R3: When several levels are pending, the highest one is presented. When trap_req_o is 1, trap_type_o equals 0x10 plus that level. When trap_req_o is 0, trap_type_o is 0.
- R4: A pending level less than or equal to pil_i produces no request. The level stays pending and is issued once pil_i drops below it.
- R5: A pending level 15 is issued even when pil_i is 15.
- R6: While trap_en_i is 0, trap_req_o is 0 at the next edge, including for level 15. Pending state is kept and is issued once trap_en_i returns to 1.
- R7: irq_i[0] has no effect on any output.
- R8: A 1 on ext_irq_i[k] latches extended source 16+k as pending. Any pending extended source raises a request on level ext_lvl_i, under the same rules as R3 to R6. ext_id_vld_o is 1 whenever an extended source is pending, and ext_id_o is then 16 plus the highest pending k.
- R9: When ext_lvl_i is 0 or 15, extended sources raise no request. They are still latched and reported on ext_id_o.
- R10: trap_ack_i while trap_req_o is 1 clears the pending bit of the presented level. If that level equals ext_lvl_i and an extended source is pending, the source shown on ext_id_o is also cleared.
- R11: trap_ack_i while trap_req_o is 0 changes no state.
- R12: ext_clr_i clears the extended source whose index k is given on ext_clr_idx_i.
- R13: When a request input is high in the same cycle that an acknowledge or clear removes the same bit, the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Request per primary level; bit 0 is ignored |
| ext_irq_i | input | 16 | Request per extended source 16+k |
| ext_lvl_i | input | 4 | Primary level used by extended sources (1 to 14 are valid) |
| pil_i | input | 4 | Processor interrupt mask level |
| trap_en_i | input | 1 | Global trap enable |
| trap_ack_i | input | 1 | Processor accepted the presented trap |
| ext_clr_i | input | 1 | Clear one extended source |
| ext_clr_idx_i | input | 4 | Index k of the extended source to clear |
| trap_req_o | output | 1 | Asynchronous trap request |
| trap_type_o | output | 8 | Trap type, 0x10 plus level |
| ext_id_vld_o | output | 1 | At least one extended source is pending |
| ext_id_o | output | 5 | Number of the highest pending extended source |

## Verification
The hardest situation to reach is the acknowledge of the shared level. Here a primary bit and several extended bits stand behind one level, and each acknowledge must peel off exactly one extended source. At the same time the mask, the enable and the configured level may be changing. Directed sequences first set up two extended sources on a chosen level and acknowledge them one at a time. They then move the configured level to the invalid codes and clear through the strobe. A long random phase follows, with sparse requests, frequent acknowledges and occasional level changes, compared each cycle against a behavioural model.

// File: rtl/pil_arbiter_pkg.sv
package pil_arbiter_pkg;
    parameter int unsigned LVL_W    = 4;
    parameter int unsigned NUM_LVL  = 1 << LVL_W;
    parameter int unsigned MAX_LVL  = NUM_LVL - 1;
    parameter int unsigned EXT_W    = 4;
    parameter int unsigned NUM_EXT  = 1 << EXT_W;
    parameter int unsigned EXT_ID_W = EXT_W + 1;
    parameter int unsigned TT_W     = 8;
    parameter logic [TT_W-1:0] TT_BASE = 8'h10;

    typedef struct packed {
        logic [NUM_LVL-1:0]  prim;
        logic [NUM_EXT-1:0]  ext;
        logic                req;
        logic [TT_W-1:0]     ttype;
        logic                idv;
        logic [EXT_ID_W-1:0] id;
    } arb_state_t;
endpackage

// File: rtl/pia_prio_enc.sv
// Finds the highest set bit of a vector.
module pia_prio_enc #(
    parameter int unsigned W  = 16,
    parameter int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = 0; i < int'(W); i++) begin
            if (vec_i[i]) begin
                idx_o = IW'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pia_ext_merge.sv
// Maps the extended bank onto one primary level as a one-hot mask.
module pia_ext_merge #(
    parameter int unsigned NLVL = 16,
    parameter int unsigned LW   = 4
) (
    input  logic            ext_any_i,
    input  logic [LW-1:0]   ext_lvl_i,
    output logic [NLVL-1:0] lvl_mask_o
);
    logic cfg_ok;

    // Level 0 is idle and the top level is reserved for non-maskable use.
    assign cfg_ok = (ext_lvl_i != '0) && (ext_lvl_i != LW'(NLVL - 1));

    for (genvar g = 0; g < int'(NLVL); g++) begin : g_lvl
        assign lvl_mask_o[g] = ext_any_i && cfg_ok && (ext_lvl_i == LW'(g));
    end
endmodule

// File: rtl/pia_level_gate.sv
// Compares the winning level with the mask and applies the trap enable.
module pia_level_gate #(
    parameter int unsigned LW = 4
) (
    input  logic          any_i,
    input  logic [LW-1:0] top_i,
    input  logic [LW-1:0] pil_i,
    input  logic          trap_en_i,
    output logic          req_o
);
    localparam logic [LW-1:0] NMI_LVL = '1;

    logic above_mask;
    logic non_maskable;

    assign above_mask   = top_i > pil_i;
    assign non_maskable = top_i == NMI_LVL;
    assign req_o        = trap_en_i && any_i && (above_mask || non_maskable);
endmodule

// File: rtl/pil_arbiter.sv
module pil_arbiter
    import pil_arbiter_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_LVL-1:0]  irq_i,
    input  logic [NUM_EXT-1:0]  ext_irq_i,
    input  logic [LVL_W-1:0]    ext_lvl_i,
    input  logic [LVL_W-1:0]    pil_i,
    input  logic                trap_en_i,
    input  logic                trap_ack_i,
    input  logic                ext_clr_i,
    input  logic [EXT_W-1:0]    ext_clr_idx_i,
    output logic                trap_req_o,
    output logic [TT_W-1:0]     trap_type_o,
    output logic                ext_id_vld_o,
    output logic [EXT_ID_W-1:0] ext_id_o
);
    localparam logic [NUM_LVL-1:0] LVL_ONE = NUM_LVL'(1);
    localparam logic [NUM_EXT-1:0] EXT_ONE = NUM_EXT'(1);

    arb_state_t st_d, st_q;

    // Signals between the next-state logic and the helper blocks.
    logic [NUM_EXT-1:0] ext_nxt;
    logic [EXT_W-1:0]   ext_hi;
    logic               ext_any;
    logic [NUM_LVL-1:0] ext_mask;
    logic [NUM_LVL-1:0] eff_lvl;
    logic [LVL_W-1:0]   top_lvl;
    logic               top_any;
    logic               req_nxt;

    pia_prio_enc #(.W(NUM_EXT), .IW(EXT_W)) u_ext_enc (
        .vec_i (ext_nxt),
        .idx_o (ext_hi),
        .any_o (ext_any)
    );

    pia_ext_merge #(.NLVL(NUM_LVL), .LW(LVL_W)) u_merge (
        .ext_any_i  (ext_any),
        .ext_lvl_i  (ext_lvl_i),
        .lvl_mask_o (ext_mask)
    );

    pia_prio_enc #(.W(NUM_LVL), .IW(LVL_W)) u_lvl_enc (
        .vec_i (eff_lvl),
        .idx_o (top_lvl),
        .any_o (top_any)
    );

    pia_level_gate #(.LW(LVL_W)) u_gate (
        .any_i     (top_any),
        .top_i     (top_lvl),
        .pil_i     (pil_i),
        .trap_en_i (trap_en_i),
        .req_o     (req_nxt)
    );

    always_comb begin
        logic               ack_hit;
        logic [LVL_W-1:0]   ack_lvl;
        logic [NUM_LVL-1:0] prim_clr;
        logic [NUM_EXT-1:0] ext_clr;

        st_d = st_q;

        // An acknowledge only counts while a trap is being presented.
        ack_hit  = trap_ack_i && st_q.req;
        ack_lvl  = st_q.ttype[LVL_W-1:0];
        prim_clr = ack_hit ? (LVL_ONE << ack_lvl) : '0;

        ext_clr = '0;
        if (ack_hit && (ack_lvl == ext_lvl_i) && st_q.idv) begin
            ext_clr = ext_clr | (EXT_ONE << st_q.id[EXT_W-1:0]);
        end
        if (ext_clr_i) begin
            ext_clr = ext_clr | (EXT_ONE << ext_clr_idx_i);
        end

        // A new request in the same cycle wins over its clear.
        st_d.prim    = (st_q.prim & ~prim_clr) | irq_i;
        st_d.prim[0] = 1'b0;
        ext_nxt      = (st_q.ext & ~ext_clr) | ext_irq_i;
        st_d.ext     = ext_nxt;

        eff_lvl    = st_d.prim | ext_mask;
        eff_lvl[0] = 1'b0;

        st_d.req   = req_nxt;
        st_d.ttype = req_nxt ? (TT_BASE + TT_W'(top_lvl)) : '0;
        st_d.idv   = ext_any;
        st_d.id    = ext_any ? (EXT_ID_W'(NUM_EXT) + EXT_ID_W'(ext_hi)) : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trap_req_o   = st_q.req;
    assign trap_type_o  = st_q.ttype;
    assign ext_id_vld_o = st_q.idv;
    assign ext_id_o     = st_q.id;
endmodule

// File: rtl/pil_arbiter_chk.sv
module pil_arbiter_chk
    import pil_arbiter_pkg::*;
(
    input logic                clk_i,
    input logic                rst_ni,
    input logic [NUM_LVL-1:0]  irq_i,
    input logic [LVL_W-1:0]    pil_i,
    input logic                trap_en_i,
    input logic                trap_req_o,
    input logic [TT_W-1:0]     trap_type_o,
    input logic                ext_id_vld_o,
    input logic [EXT_ID_W-1:0] ext_id_o
);
    // R3
    type_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_req_o |-> (trap_type_o > TT_BASE) && (trap_type_o <= TT_BASE + TT_W'(MAX_LVL)));

    // R3
    idle_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trap_req_o |-> (trap_type_o == '0));

    // R4
    above_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_req_o && (trap_type_o != TT_BASE + TT_W'(MAX_LVL)))
            |-> (trap_type_o[LVL_W-1:0] > $past(pil_i)));

    // R5
    nmi_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_en_i && irq_i[MAX_LVL])
            |=> (trap_req_o && (trap_type_o == TT_BASE + TT_W'(MAX_LVL))));

    // R6
    trap_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trap_en_i |=> !trap_req_o);

    // R8
    ext_id_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_id_vld_o |-> (ext_id_o >= EXT_ID_W'(NUM_EXT)));

    // R8
    ext_id_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ext_id_vld_o |-> (ext_id_o == '0));
endmodule

bind pil_arbiter pil_arbiter_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_i        (irq_i),
    .pil_i        (pil_i),
    .trap_en_i    (trap_en_i),
    .trap_req_o   (trap_req_o),
    .trap_type_o  (trap_type_o),
    .ext_id_vld_o (ext_id_vld_o),
    .ext_id_o     (ext_id_o)
);

// File: tb/tb_pil_arbiter.sv
module tb_pil_arbiter;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [15:0] irq_i = '0;
    logic [15:0] ext_irq_i = '0;
    logic [3:0]  ext_lvl_i = '0;
    logic [3:0]  pil_i = '0;
    logic        trap_en_i = 1'b0;
    logic        trap_ack_i = 1'b0;
    logic        ext_clr_i = 1'b0;
    logic [3:0]  ext_clr_idx_i = '0;
    logic        trap_req_o;
    logic [7:0]  trap_type_o;
    logic        ext_id_vld_o;
    logic [4:0]  ext_id_o;

    pil_arbiter dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .ext_irq_i(ext_irq_i),
        .ext_lvl_i(ext_lvl_i), .pil_i(pil_i), .trap_en_i(trap_en_i),
        .trap_ack_i(trap_ack_i), .ext_clr_i(ext_clr_i), .ext_clr_idx_i(ext_clr_idx_i),
        .trap_req_o(trap_req_o), .trap_type_o(trap_type_o),
        .ext_id_vld_o(ext_id_vld_o), .ext_id_o(ext_id_o)
    );

    always #10 clk_i = ~clk_i;

    int    n_vec = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // Behavioural reference state.
    logic [15:0] m_prim = '0;
    logic [15:0] m_ext = '0;
    int          m_type = 0;
    bit          m_req = 1'b0;
    bit          m_idv = 1'b0;
    int          m_id = 0;

    function automatic int top_bit(input logic [15:0] v);
        int r = -1;
        for (int i = 0; i < 16; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic compare();
        n_vec++;
        if (trap_req_o !== m_req || trap_type_o !== 8'(m_type) ||
            ext_id_vld_o !== m_idv || ext_id_o !== 5'(m_id)) begin
            n_bad++;
            $display("FAIL %s: req=%0b type=%h idv=%0b id=%0d expected req=%0b type=%h idv=%0b id=%0d",
                     tag, trap_req_o, trap_type_o, ext_id_vld_o, ext_id_o,
                     m_req, 8'(m_type), m_idv, m_id);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, check after the edge.
    task automatic step(input logic [15:0] prim, input logic [15:0] ext,
                        input int pil, input bit en, input bit ack,
                        input bit clr, input int cidx, input int elvl);
        logic [15:0] np, ne, eff;
        int ack_lvl, top, ehi;
        bit ack_hit;
        irq_i = prim; ext_irq_i = ext; pil_i = 4'(pil); trap_en_i = en;
        trap_ack_i = ack; ext_clr_i = clr; ext_clr_idx_i = 4'(cidx); ext_lvl_i = 4'(elvl);
        ack_hit = ack && m_req;
        ack_lvl = m_type - 16;
        np = m_prim;
        if (ack_hit) np[ack_lvl] = 1'b0;
        np = np | prim;
        np[0] = 1'b0;
        ne = m_ext;
        if (ack_hit && ack_lvl == elvl && m_idv) ne[m_id - 16] = 1'b0;
        if (clr) ne[cidx] = 1'b0;
        ne = ne | ext;
        eff = np;
        if (elvl >= 1 && elvl <= 14 && ne != 0) eff[elvl] = 1'b1;
        top = top_bit(eff);
        @(posedge clk_i);
        m_prim = np;
        m_ext = ne;
        m_req = en && top > 0 && (top == 15 || top > pil);
        m_type = m_req ? 16 + top : 0;
        ehi = top_bit(ne);
        m_idv = ne != 0;
        m_id = m_idv ? 16 + ehi : 0;
        @(negedge clk_i);
        compare();
    endtask

    task automatic idle(input int pil, input int elvl);
        step('0, '0, pil, 1'b1, 1'b0, 1'b0, 0, elvl);
    endtask

    task automatic ack(input int pil, input int elvl);
        step('0, '0, pil, 1'b1, 1'b1, 1'b0, 0, elvl);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
    end

    initial begin
        // R1: reset values while reset is held and just after release.
        tag = "R1";
        repeat (3) begin @(negedge clk_i); compare(); end
        rst_ni = 1'b1;
        idle(0, 0);

        // R7: level 0 input ignored.
        tag = "R7";
        step(16'h0001, '0, 0, 1, 0, 0, 0, 0);
        idle(0, 0);

        // R2: pulse latches and holds.
        tag = "R2";
        step(16'h0008, '0, 0, 1, 0, 0, 0, 0);
        idle(0, 0); idle(0, 0);

        // R3: highest wins.
        tag = "R3";
        step(16'h0220, '0, 0, 1, 0, 0, 0, 0);
        idle(0, 0);

        // R10: acknowledges peel levels 9, 5, 3.
        tag = "R10";
        ack(0, 0); ack(0, 0); ack(0, 0); idle(0, 0);

        // R4: mask level behaviour.
        tag = "R4";
        step(16'h0020, '0, 7, 1, 0, 0, 0, 0);
        idle(7, 0);
        step(16'h0080, '0, 7, 1, 0, 0, 0, 0);
        step(16'h0100, '0, 7, 1, 0, 0, 0, 0);
        ack(7, 0);
        idle(0, 0);
        ack(0, 0); ack(0, 0);

        // R5: level 15 passes mask 15.
        tag = "R5";
        step(16'h8000, '0, 15, 1, 0, 0, 0, 0);
        step(16'h4000, '0, 15, 1, 0, 0, 0, 0);
        ack(15, 0);
        idle(15, 0);
        idle(0, 0);
        ack(0, 0);

        // R6: trap enable gates everything.
        tag = "R6";
        step(16'h8000, '0, 0, 0, 0, 0, 0, 0);
        step('0, '0, 0, 0, 1, 0, 0, 0);
        step('0, '0, 0, 1, 0, 0, 0, 0);
        ack(0, 0);

        // R8: extended sources on level 6.
        tag = "R8";
        step('0, 16'h0204, 0, 1, 0, 0, 0, 6);
        idle(0, 6);
        ack(0, 6);
        ack(0, 6);
        idle(0, 6);

        // R9: invalid shared level codes.
        tag = "R9";
        step('0, 16'h0010, 0, 1, 0, 0, 0, 15);
        idle(0, 0);
        idle(0, 15);

        // R12: clear through the strobe.
        tag = "R12";
        step('0, '0, 0, 1, 0, 1, 4, 15);
        step('0, 16'h000A, 0, 1, 0, 0, 0, 6);
        step('0, '0, 0, 1, 0, 1, 3, 6);
        step('0, '0, 0, 1, 0, 1, 1, 6);

        // R11: acknowledge with no request.
        tag = "R11";
        step(16'h0020, '0, 15, 1, 0, 0, 0, 0);
        step('0, '0, 15, 1, 1, 0, 0, 0);
        idle(0, 0);
        ack(0, 0);

        // R13: set beats acknowledge and clear on the same bit.
        tag = "R13";
        step(16'h0010, '0, 0, 1, 0, 0, 0, 0);
        step(16'h0010, '0, 0, 1, 1, 0, 0, 0);
        ack(0, 0);
        step('0, 16'h0004, 0, 1, 0, 0, 0, 3);
        step('0, 16'h0004, 0, 1, 0, 1, 2, 3);
        ack(0, 3);

        // R3: random mix against the model.
        tag = "R3 random";
        begin
            int elvl = 6;
            for (int c = 0; c < 4000; c++) begin
                logic [15:0] p, e;
                p = 16'($urandom & $urandom & $urandom);
                e = 16'($urandom & $urandom & $urandom & $urandom);
                if ($urandom % 50 == 0) elvl = $urandom % 16;
                step(p, e, $urandom % 16, ($urandom % 8) != 0, $urandom % 2,
                     ($urandom % 10) == 0, $urandom % 16, elvl);
            end
        end

        summary();
    end
endmodule